// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit for a multi-cycle 32-bit load/store datapath. That datapath has one shared memory for instructions and data, one shared ALU, an instruction register, two operand latches, an ALU-result register and a memory-data register. The sequencer is a Moore state machine with ten states. Its only steering input is the 6-bit opcode held in the instruction register. Every control output is decoded from the current state alone. The single exception is the final PC load strobe, which also folds in the ALU equality flag.

Each instruction starts with a fetch cycle and a decode cycle. The decode cycle latches both source registers and precomputes the branch target. The opcode then selects a class-specific path: loads, stores, register-register arithmetic, branch-on-equal and absolute jump. Instructions take between three and five cycles. An opcode outside these five classes ends the instruction right after decode, without writing memory, registers or the PC.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the sequencer in state 0 at that edge, whatever the opcode. `state_o` always reports the current state number (0 to 9).
- R2: State 0 (fetch) asserts `mem_rd_o`, `ir_ld_o` and `pc_wr_o`, and `pc_load_o` is 1. It also drives `addr_sel_o`=0 (address from PC), `alu_a_sel_o`=0 (PC), `alu_b_sel_o`=2'b01 (constant 4), `alu_op_o`=2'b00 (add) and `pc_src_o`=2'b00 (live ALU result). The next state is always 1.
- R3: State 1 (decode) asserts `ab_ld_o` and `aluout_ld_o`, with `alu_a_sel_o`=0, `alu_b_sel_o`=2'b11 (sign-extended offset shifted left by 2) and `alu_op_o`=2'b00. No memory, register-file or PC write happens in this state.
- R4: From state 1, opcode 6'h23 (load) or 6'h2B (store) goes to state 2, 6'h00 (register type) goes to 6, 6'h04 (branch-equal) goes to 8, 6'h02 (jump) goes to 9. Any other opcode goes back to 0.
- R5: State 2 asserts `aluout_ld_o`, with `alu_a_sel_o`=1 (A), `alu_b_sel_o`=2'b10 (sign-extended immediate) and `alu_op_o`=2'b00. It goes to 3 for opcode 6'h23 and to 5 for 6'h2B.
- R6: State 3 asserts `mem_rd_o` and `mdr_ld_o` with `addr_sel_o`=1 (address from the ALU-result register) and goes to 4. State 4 asserts `reg_wr_o` with `reg_dst_o`=0 (destination field bits 20:16) and `wb_sel_o`=1 (memory data), then goes to 0.
- R7: State 5 asserts `mem_wr_o` with `addr_sel_o`=1 and goes to 0.
- R8: State 6 asserts `aluout_ld_o`, with `alu_a_sel_o`=1, `alu_b_sel_o`=2'b00 (B) and `alu_op_o`=2'b10 (operation from function field), then goes to 7. State 7 asserts `reg_wr_o` with `reg_dst_o`=1 (bits 15:11) and `wb_sel_o`=0 (ALU-result register), then goes to 0.
- R9: State 8 asserts `pc_wr_cond_o`, with `alu_a_sel_o`=1, `alu_b_sel_o`=2'b00, `alu_op_o`=2'b01 (subtract) and `pc_src_o`=2'b01 (ALU-result register), then goes to 0.
- R10: State 9 asserts `pc_wr_o` with `pc_src_o`=2'b10 (upper PC bits joined with the shifted jump index) and goes to 0.
- R11: Measured from one fetch to the next, a load takes 5 cycles, a store 4, a register-type instruction 4, a branch 3, a jump 3 and an unrecognised opcode 2.
- R12: In every state, any strobe that R2 to R10 do not name for that state is 0. `mem_rd_o` and `mem_wr_o` are never both 1. At most one of `reg_wr_o`, `mem_wr_o`, `pc_wr_o` is 1.
- R13: `pc_load_o` is 1 exactly when `pc_wr_o` is 1, or when `pc_wr_cond_o` is 1 and `a_eq_b_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field from the instruction register |
| a_eq_b_i | input | 1 | ALU equality flag (operands equal) |
| state_o | output | 4 | Current state number |
| ir_ld_o | output | 1 | Load instruction register |
| ab_ld_o | output | 1 | Load A and B operand latches |
| aluout_ld_o | output | 1 | Load ALU-result register |
| mdr_ld_o | output | 1 | Load memory-data register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU-result register |
| alu_a_sel_o | output | 1 | ALU A input: 0 PC, 1 A latch |
| alu_b_sel_o | output | 2 | ALU B input: 00 B, 01 four, 10 immediate, 11 offset<<2 |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 function field |
| reg_wr_o | output | 1 | Register-file write |
| reg_dst_o | output | 1 | Write index: 0 bits 20:16, 1 bits 15:11 |
| wb_sel_o | output | 1 | Write data: 0 ALU-result register, 1 memory data |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU-result register, 10 jump |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write if operands equal |
| pc_load_o | output | 1 | Final PC load strobe |

## Verification
The bench runs each of the five instruction classes in turn, then two undefined opcodes (6'h3F and 6'h08). The class runs tell apart the four dispatch targets out of decode and the two targets out of address calculation. The undefined opcodes show that the early return to fetch happens with no write strobe. A branch is issued once with the equality flag set and once with it clear, which separates the conditional PC load from the unconditional one. A load is cut off by reset in its memory-read cycle, which shows that reset overrides the opcode path mid-instruction. Every cycle the full control word is compared, and the gap between successive fetches is timed per class.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPW = 6;
  localparam int STW = 4;

  localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPW-1:0] OP_JUMP  = 6'h02;
  localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPW-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPW-1:0] OP_STORE = 6'h2B;

  typedef enum logic [STW-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_MRD    = 4'd3,
    S_LDWB   = 4'd4,
    S_MWR    = 4'd5,
    S_EXEC   = 4'd6,
    S_RWB    = 4'd7,
    S_BRN    = 4'd8,
    S_JMP    = 4'd9
  } state_e;

  localparam logic [1:0] BSRC_REG  = 2'b00;
  localparam logic [1:0] BSRC_FOUR = 2'b01;
  localparam logic [1:0] BSRC_IMM  = 2'b10;
  localparam logic [1:0] BSRC_OFS  = 2'b11;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [1:0] PCS_ALU   = 2'b00;
  localparam logic [1:0] PCS_OUT   = 2'b01;
  localparam logic [1:0] PCS_JMP   = 2'b10;

  typedef struct packed {
    logic       ir_ld;
    logic       ab_ld;
    logic       aluout_ld;
    logic       mdr_ld;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       reg_wr;
    logic       reg_dst;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic       pc_wr;
    logic       pc_wr_cond;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

  // Successor state from the current state and the held opcode.
  function automatic state_e step_state(input state_e cur, input logic [OPW-1:0] op);
    state_e nxt;
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (op == OP_LOAD || op == OP_STORE) nxt = S_ADDR;
        else if (op == OP_RTYPE)             nxt = S_EXEC;
        else if (op == OP_BEQ)               nxt = S_BRN;
        else if (op == OP_JUMP)              nxt = S_JMP;
        else                                 nxt = S_FETCH;
      end
      S_ADDR: begin
        if (op == OP_LOAD)       nxt = S_MRD;
        else if (op == OP_STORE) nxt = S_MWR;
        else                     nxt = S_FETCH;
      end
      S_MRD:    nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
    return nxt;
  endfunction

  // Moore control word for one state.
  function automatic ctrl_t state_ctrl(input state_e cur);
    ctrl_t c;
    c = CTRL_IDLE;
    case (cur)
      S_FETCH: begin
        c.mem_rd    = 1'b1;
        c.ir_ld     = 1'b1;
        c.alu_b_sel = BSRC_FOUR;
        c.alu_op    = AOP_ADD;
        c.pc_src    = PCS_ALU;
        c.pc_wr     = 1'b1;
      end
      S_DECODE: begin
        c.ab_ld     = 1'b1;
        c.aluout_ld = 1'b1;
        c.alu_b_sel = BSRC_OFS;
        c.alu_op    = AOP_ADD;
      end
      S_ADDR: begin
        c.aluout_ld = 1'b1;
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSRC_IMM;
        c.alu_op    = AOP_ADD;
      end
      S_MRD: begin
        c.mem_rd   = 1'b1;
        c.addr_sel = 1'b1;
        c.mdr_ld   = 1'b1;
      end
      S_LDWB: begin
        c.reg_wr  = 1'b1;
        c.reg_dst = 1'b0;
        c.wb_sel  = 1'b1;
      end
      S_MWR: begin
        c.mem_wr   = 1'b1;
        c.addr_sel = 1'b1;
      end
      S_EXEC: begin
        c.aluout_ld = 1'b1;
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSRC_REG;
        c.alu_op    = AOP_FUNCT;
      end
      S_RWB: begin
        c.reg_wr  = 1'b1;
        c.reg_dst = 1'b1;
        c.wb_sel  = 1'b0;
      end
      S_BRN: begin
        c.alu_a_sel  = 1'b1;
        c.alu_b_sel  = BSRC_REG;
        c.alu_op     = AOP_SUB;
        c.pc_src     = PCS_OUT;
        c.pc_wr_cond = 1'b1;
      end
      S_JMP: begin
        c.pc_src = PCS_JMP;
        c.pc_wr  = 1'b1;
      end
      default: c = CTRL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_e         cur_i,
  input  logic [OPW-1:0] opcode_i,
  output state_e         nxt_o
);
  always_comb nxt_o = step_state(cur_i, opcode_i);
endmodule

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_e nxt_i,
  output state_e cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= S_FETCH;
    else     cur_o <= nxt_i;
  end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_e cur_i,
  output ctrl_t  ctrl_o
);
  always_comb ctrl_o = state_ctrl(cur_i);
endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode_i,
  input  logic       a_eq_b_i,
  output logic [3:0] state_o,
  output logic       ir_ld_o,
  output logic       ab_ld_o,
  output logic       aluout_ld_o,
  output logic       mdr_ld_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       addr_sel_o,
  output logic       alu_a_sel_o,
  output logic [1:0] alu_b_sel_o,
  output logic [1:0] alu_op_o,
  output logic       reg_wr_o,
  output logic       reg_dst_o,
  output logic       wb_sel_o,
  output logic [1:0] pc_src_o,
  output logic       pc_wr_o,
  output logic       pc_wr_cond_o,
  output logic       pc_load_o
);

  state_e cur_st;
  state_e nxt_st;
  ctrl_t  ctrl;
  logic   branch_taken;

  mcc_next_state u_next (
    .cur_i    (cur_st),
    .opcode_i (opcode_i),
    .nxt_o    (nxt_st)
  );

  mcc_state_reg u_sreg (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt_st),
    .cur_o (cur_st)
  );

  mcc_ctrl_decode u_dec (
    .cur_i  (cur_st),
    .ctrl_o (ctrl)
  );

  assign branch_taken = ctrl.pc_wr_cond & a_eq_b_i;

  assign state_o      = cur_st;
  assign ir_ld_o      = ctrl.ir_ld;
  assign ab_ld_o      = ctrl.ab_ld;
  assign aluout_ld_o  = ctrl.aluout_ld;
  assign mdr_ld_o     = ctrl.mdr_ld;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign addr_sel_o   = ctrl.addr_sel;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign reg_wr_o     = ctrl.reg_wr;
  assign reg_dst_o    = ctrl.reg_dst;
  assign wb_sel_o     = ctrl.wb_sel;
  assign pc_src_o     = ctrl.pc_src;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign pc_load_o    = ctrl.pc_wr | branch_taken;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode_i,
  input logic       a_eq_b_i,
  input logic [3:0] state_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       reg_wr_o,
  input logic       pc_wr_o,
  input logic       pc_load_o
);

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> state_o == 4'd0);

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd0 |=> state_o == 4'd1);

  // R4
  beq_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd1 && opcode_i == 6'h04) |=> state_o == 4'd8);

  // R6
  mrd_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd3 |=> state_o == 4'd4);

  // R8
  exec_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd6 |=> state_o == 4'd7);

  // R12
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  // R12
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_wr_o, mem_wr_o, pc_wr_o}) <= 1);

  // R13
  jump_loads_pc_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd9 |-> pc_load_o);

  // R13
  untaken_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd8 && !a_eq_b_i) |-> !pc_load_o);

endmodule

bind mcc_ctrl_fsm mcc_ctrl_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode_i  (opcode_i),
  .a_eq_b_i  (a_eq_b_i),
  .state_o   (state_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .reg_wr_o  (reg_wr_o),
  .pc_wr_o   (pc_wr_o),
  .pc_load_o (pc_load_o)
);

// File: tb/test_mcc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_mcc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode_i = 6'h00;
  logic       a_eq_b_i = 1'b0;
  logic [3:0] state_o;
  logic       ir_ld_o, ab_ld_o, aluout_ld_o, mdr_ld_o, mem_rd_o, mem_wr_o;
  logic       addr_sel_o, alu_a_sel_o, reg_wr_o, reg_dst_o, wb_sel_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_src_o;
  logic       pc_wr_o, pc_wr_cond_o, pc_load_o;

  always #2 clk = ~clk;

  mcc_ctrl_fsm i_mcc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode_i(opcode_i), .a_eq_b_i(a_eq_b_i),
    .state_o(state_o), .ir_ld_o(ir_ld_o), .ab_ld_o(ab_ld_o),
    .aluout_ld_o(aluout_ld_o), .mdr_ld_o(mdr_ld_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .addr_sel_o(addr_sel_o), .alu_a_sel_o(alu_a_sel_o),
    .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o), .reg_wr_o(reg_wr_o),
    .reg_dst_o(reg_dst_o), .wb_sel_o(wb_sel_o), .pc_src_o(pc_src_o),
    .pc_wr_o(pc_wr_o), .pc_wr_cond_o(pc_wr_cond_o), .pc_load_o(pc_load_o)
  );

  typedef struct {
    logic       rst;
    logic [5:0] op;
    logic       eq;
    logic       chk;
    int         st;
    int         prev_len;
  } item_t;

  item_t sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  int    last_len = 0;
  bit    drv_done = 0;

  // Fetch-to-fetch length per class (R11)
  function automatic int class_len(input logic [5:0] op);
    case (op)
      6'h23:   return 5;
      6'h2B:   return 4;
      6'h00:   return 4;
      6'h04:   return 3;
      6'h02:   return 3;
      default: return 2;
    endcase
  endfunction

  // Expected {ir,ab,aluout,mdr,rd,wr,addr,asel,bsel[2],aop[2],regwr,dst,wb,pcsrc[2],pcwr,cond,load}
  function automatic logic [19:0] exp_word(input int st, input logic eq);
    logic ir, ab, ao, mdr, rd, wr, ad, as, rw, ds, wb, pw, pc;
    logic [1:0] bs, op, ps;
    {ir, ab, ao, mdr, rd, wr, ad, as, rw, ds, wb, pw, pc} = '0;
    bs = 2'b00; op = 2'b00; ps = 2'b00;
    case (st)
      0: begin rd = 1; ir = 1; pw = 1; bs = 2'b01; end                 // R2
      1: begin ab = 1; ao = 1; bs = 2'b11; end                         // R3
      2: begin ao = 1; as = 1; bs = 2'b10; end                         // R5
      3: begin rd = 1; ad = 1; mdr = 1; end                            // R6
      4: begin rw = 1; wb = 1; end                                     // R6
      5: begin wr = 1; ad = 1; end                                     // R7
      6: begin ao = 1; as = 1; op = 2'b10; end                         // R8
      7: begin rw = 1; ds = 1; end                                     // R8
      8: begin as = 1; op = 2'b01; ps = 2'b01; pc = 1; end             // R9
      9: begin pw = 1; ps = 2'b10; end                                 // R10
      default: ;
    endcase
    return {ir, ab, ao, mdr, rd, wr, ad, as, bs, op, rw, ds, wb, ps, pw, pc,
            pw | (pc & eq)};                                           // R13
  endfunction

  function automatic string tag_of(input int st);
    case (st)
      0: return "R2"; 1: return "R3"; 2: return "R5"; 3: return "R6"; 4: return "R6";
      5: return "R7"; 6: return "R8"; 7: return "R8"; 8: return "R9,R13"; 9: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic push(input logic r, input logic [5:0] op, input logic eq,
                      input logic chk, input int st, input int pl);
    item_t it;
    it.rst = r; it.op = op; it.eq = eq; it.chk = chk; it.st = st; it.prev_len = pl;
    sb_q.push_back(it);
  endtask

  // Driver: one instruction; abort_at is the step at which reset is applied (-1 none)
  task automatic drive_instr(input logic [5:0] op, input logic eq, input int abort_at);
    int seq[$];
    seq = '{0, 1};
    case (op)                                                          // R4, R5
      6'h23: begin seq.push_back(2); seq.push_back(3); seq.push_back(4); end
      6'h2B: begin seq.push_back(2); seq.push_back(5); end
      6'h00: begin seq.push_back(6); seq.push_back(7); end
      6'h04: seq.push_back(8);
      6'h02: seq.push_back(9);
      default: ;
    endcase
    foreach (seq[i]) begin
      push(i == abort_at, op, eq, 1'b1, seq[i], (i == 0) ? last_len : 0);
      if (i == abort_at) break;
    end
    last_len = (abort_at >= 0) ? 0 : class_len(op);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) push(1'b1, 6'h23, 1'b0, 1'b0, 0, 0);   // R1 initial reset
    drive_instr(6'h23, 1'b0, -1);
    drive_instr(6'h2B, 1'b0, -1);
    drive_instr(6'h00, 1'b0, -1);
    drive_instr(6'h04, 1'b1, -1);
    drive_instr(6'h04, 1'b0, -1);
    drive_instr(6'h02, 1'b1, -1);
    drive_instr(6'h3F, 1'b1, -1);                                      // R4 undefined opcode
    drive_instr(6'h08, 1'b0, -1);
    drive_instr(6'h23, 1'b1, 3);                                       // R1 reset mid-load
    drive_instr(6'h00, 1'b1, -1);
    drive_instr(6'h23, 1'b0, -1);
    push(1'b0, 6'h02, 1'b0, 1'b1, 0, last_len);
    drv_done = 1;
  end

  // Monitor: pops one expected item per cycle, applies its inputs, compares
  initial begin : monitor
    int cnt;
    logic [19:0] got, exp;
    item_t it;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (sb_q.size() == 0) begin
        if (drv_done) break;
      end else begin
        it = sb_q.pop_front();
        rst = it.rst; opcode_i = it.op; a_eq_b_i = it.eq;
        #0.5;
        if (it.chk) begin
          got = {ir_ld_o, ab_ld_o, aluout_ld_o, mdr_ld_o, mem_rd_o, mem_wr_o, addr_sel_o,
                 alu_a_sel_o, alu_b_sel_o, alu_op_o, reg_wr_o, reg_dst_o, wb_sel_o,
                 pc_src_o, pc_wr_o, pc_wr_cond_o, pc_load_o};
          exp = exp_word(it.st, it.eq);
          n_chk++;
          if (state_o != it.st[3:0]) begin
            n_fail++;
            $display("FAIL R1/R4 state: got %0d expected %0d", state_o, it.st);
          end
          n_chk++;
          if (got != exp) begin
            n_fail++;
            $display("FAIL %s,R12 controls in state %0d: got %h expected %h",
                     tag_of(it.st), it.st, got, exp);
          end
          if (state_o == 4'd0) begin
            if (it.prev_len != 0) begin
              n_chk++;
              if (cnt != it.prev_len) begin
                n_fail++;
                $display("FAIL R11 cycle count: got %0d expected %0d", cnt, it.prev_len);
              end
            end
            cnt = 1;
          end else begin
            cnt++;
          end
        end
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule